// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a snapshot of a free-running timer count when a chosen edge shows up on a trigger signal. The trigger can come from an external capture pin or from an analog comparator output, and one control bit picks between them. Both inputs pass through a two-stage synchronizer. The selected level can then go through an optional majority-free digital filter. This filter only changes its output after four consecutive agreeing samples. After that comes a polarity-selectable edge detector. Each accepted edge loads the count into a 16-bit capture register and raises a sticky capture flag. Software clears the flag with a strobe. The interrupt request is the flag gated by an enable.

Software sees the capture register through a byte-wide port that keeps 16-bit accesses consistent. Reading the low byte returns it at once and parks the high byte in a shared temporary byte, which a later high-byte read returns. In the mode where the capture register acts as the counter's TOP value, software writes the high byte into that temporary byte first, and the write of the low byte commits all 16 bits. In that mode, trigger edges never cause a capture.

Top module: `tmr_capture_unit`

## Requirements
- R1: `src_sel_cmp`=0 selects `pin_in` and 1 selects `cmp_in`; the unselected input never causes a capture. Unfiltered, an input change set up before clock edge k loads `cap_val` and sets `cap_flag` at edge k+2 (not at k+1), with the `tmr_count` value present at that edge.
- R2: `edge_rise`=1 captures on a 0→1 transition of the selected trigger and `edge_rise`=0 on a 1→0 transition; the opposite transition causes no capture.
- R3: Changing `src_sel_cmp` while the two synchronized inputs differ is itself a transition of the trigger and captures on the edge after the change if its direction matches `edge_rise`; `flag_clr` then clears the flag.
- R4: With `filt_en`=1, a trigger level held for fewer than four consecutive samples is ignored (no capture).
- R5: With `filt_en`=1, a clean input change is captured exactly four clock edges later than unfiltered (edge k+6). The filter samples at every system clock.
- R6: A new capture overwrites `cap_val` even if the previous value was never read; the flag stays set.
- R7: While `cap_is_top`=1, no trigger edge changes `cap_val` or sets `cap_flag`.
- R8: A pulse on `bus_wr_hi` stores `bus_wdata` in the temporary byte and leaves `cap_val` unchanged. A pulse on `bus_wr_lo` loads `cap_val` with {temporary byte, `bus_wdata`}.
- R9: While `bus_rd_lo`=1, `bus_rdata` shows `cap_val[7:0]` in the same cycle, and that edge copies `cap_val[15:8]` into the temporary byte. While `bus_rd_hi`=1, `bus_rdata` shows the temporary byte, even if `cap_val` has changed since. With no read strobe, `bus_rdata` is 0.
- R10: `cap_flag` sets on the edge that loads `cap_val` and holds until `flag_clr`. When a capture and `flag_clr` occur in the same cycle, the flag ends up set. `cap_irq` = `cap_flag` AND `irq_en`.
- R11: After reset, `cap_val`=0, `cap_flag`=0, `cap_irq`=0 and `bus_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_count | input | 16 | Free-running timer count |
| pin_in | input | 1 | External capture pin (asynchronous) |
| cmp_in | input | 1 | Comparator output (asynchronous) |
| src_sel_cmp | input | 1 | 1: comparator is trigger, 0: pin |
| edge_rise | input | 1 | 1: rising edge, 0: falling edge |
| filt_en | input | 1 | Enable four-sample noise filter |
| cap_is_top | input | 1 | Capture register serves as counter TOP; captures blocked |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear strobe for the capture flag |
| bus_wdata | input | 8 | Write data byte |
| bus_wr_hi | input | 1 | Write high byte into temporary byte |
| bus_wr_lo | input | 1 | Write low byte and commit 16 bits |
| bus_rd_lo | input | 1 | Read low byte, latch high byte |
| bus_rd_hi | input | 1 | Read latched high byte |
| bus_rdata | output | 8 | Read data byte |
| cap_val | output | 16 | Capture register |
| cap_flag | output | 1 | Capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The bench counts clock edges from each input change to the flag rising. It checks the exact unfiltered and filtered latencies, so a design with a synchronizer stage too many or too few, or a filter that counts five samples, fails at once. A three-sample glitch under the filter must produce no capture, which catches a filter that compares too few samples. A source switch between unequal inputs must capture, and a capture coinciding with a clear strobe must leave the flag set; a design that gated the switch or let the clear win would lose the event. Byte access is exercised so that a high-byte write alone must not move the register, and a high-byte read after a fresh capture must still return the byte latched by the earlier low read.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  parameter int unsigned BYTE_W      = 8;
  parameter int unsigned SYNC_STAGES = 2;
  parameter int unsigned FILT_TAPS   = 4;

  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned HIST_W = FILT_TAPS - 1;
  localparam int unsigned N_SRC  = 2;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;

  // True when the current sample and every stored sample hold the same level.
  function automatic logic samples_agree(input logic [HIST_W-1:0] hist,
                                         input logic cur);
    return (cur && (&hist)) || (!cur && !(|hist));
  endfunction

  // Transition of the requested polarity between previous and present level.
  function automatic logic edge_match(input edge_kind_e kind,
                                      input logic prev, input logic now);
    return (kind == EDGE_RISE) ? (now && !prev) : (!now && prev);
  endfunction

  function automatic logic [CNT_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/tcap_filter.sv
module tcap_filter
  import tcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);

  logic [HIST_W-1:0] hist_q;
  logic              filt_q;
  logic              agree;

  assign agree = samples_agree(hist_q, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[HIST_W-2:0], din};
      if (agree) filt_q <= din;
    end
  end

  assign dout = en ? filt_q : din;

  // A filtered level may only move to a value the stored history already held throughout.
  AST_FILT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> ($past(hist_q) == {HIST_W{filt_q}})); // R4

endmodule

// File: rtl/tcap_edge.sv
module tcap_edge
  import tcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic rise_sel,
  input  logic block,
  output logic evt
);

  logic       level_q;
  edge_kind_e kind;

  assign kind = rise_sel ? EDGE_RISE : EDGE_FALL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign evt = edge_match(kind, level_q, level) && !block;

  AST_EDGE_DIR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && rise_sel) |=> level_q); // R2
  AST_EDGE_DIR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !rise_sel) |=> !level_q); // R2

endmodule

// File: rtl/tcap_regfile.sv
module tcap_regfile
  import tcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [CNT_W-1:0]  count,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rdata,
  output logic [CNT_W-1:0]  cap_q
);

  logic [BYTE_W-1:0] temp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (wr_lo) begin
      cap_q <= join_bytes(temp_q, wdata);
    end else if (load_evt) begin
      cap_q <= count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
    end else if (wr_hi) begin
      temp_q <= wdata;
    end else if (rd_lo) begin
      temp_q <= cap_q[CNT_W-1:BYTE_W];
    end
  end

  always_comb begin
    if (rd_lo)      rdata = cap_q[BYTE_W-1:0];
    else if (rd_hi) rdata = temp_q;
    else            rdata = '0;
  end

  AST_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_lo) |=> (cap_q == $past(count))); // R6
  AST_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !load_evt) |=> $stable(cap_q)); // R8
  AST_RD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !wr_hi) |=> (temp_q == $past(cap_q[CNT_W-1:BYTE_W]))); // R9

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tmr_count,
  input  logic              pin_in,
  input  logic              cmp_in,
  input  logic              src_sel_cmp,
  input  logic              edge_rise,
  input  logic              filt_en,
  input  logic              cap_is_top,
  input  logic              irq_en,
  input  logic              flag_clr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr_hi,
  input  logic              bus_wr_lo,
  input  logic              bus_rd_lo,
  input  logic              bus_rd_hi,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  cap_val,
  output logic              cap_flag,
  output logic              cap_irq
);

  logic [N_SRC-1:0] raw_src;
  logic [N_SRC-1:0] sync_src;
  logic             trig_lvl;
  logic             filt_lvl;
  logic             cap_evt;
  logic             flag_q;

  assign raw_src = {cmp_in, pin_in};

  for (genvar g = 0; g < N_SRC; g++) begin : g_sync
    tcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_src[g]),
      .sync_out (sync_src[g])
    );
  end

  // Source mux after synchronization: a switch between unequal levels is a transition.
  assign trig_lvl = sync_src[src_sel_cmp];

  tcap_filter u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (filt_en),
    .din   (trig_lvl),
    .dout  (filt_lvl)
  );

  tcap_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (filt_lvl),
    .rise_sel (edge_rise),
    .block    (cap_is_top),
    .evt      (cap_evt)
  );

  tcap_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (cap_evt),
    .count    (tmr_count),
    .wdata    (bus_wdata),
    .wr_hi    (bus_wr_hi),
    .wr_lo    (bus_wr_lo),
    .rd_lo    (bus_rd_lo),
    .rd_hi    (bus_rd_hi),
    .rdata    (bus_rdata),
    .cap_q    (cap_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (cap_evt)  flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign cap_flag = flag_q;
  assign cap_irq  = flag_q && irq_en;

  AST_FLAG_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag); // R10
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag); // R10
  AST_TOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_is_top && !bus_wr_lo) |=> $stable(cap_val)); // R7
  AST_TOP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_is_top && !cap_flag) |=> !cap_flag); // R7

endmodule

// File: tb/tmr_capture_unit_tb_top.sv
module tmr_capture_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_count = 16'h0000;
  logic        pin_in = 1'b0, cmp_in = 1'b0;
  logic        src_sel_cmp = 1'b0, edge_rise = 1'b1, filt_en = 1'b0;
  logic        cap_is_top = 1'b0, irq_en = 1'b1, flag_clr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_wr_hi = 1'b0, bus_wr_lo = 1'b0, bus_rd_lo = 1'b0, bus_rd_hi = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] cap_val;
  logic        cap_flag, cap_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // Count advances on the falling edge, so it is stable at each rising edge.
  always @(negedge clk) tmr_count <= tmr_count + 16'h0101;

  tmr_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count),
    .pin_in(pin_in), .cmp_in(cmp_in), .src_sel_cmp(src_sel_cmp),
    .edge_rise(edge_rise), .filt_en(filt_en), .cap_is_top(cap_is_top),
    .irq_en(irq_en), .flag_clr(flag_clr), .bus_wdata(bus_wdata),
    .bus_wr_hi(bus_wr_hi), .bus_wr_lo(bus_wr_lo), .bus_rd_lo(bus_rd_lo),
    .bus_rd_hi(bus_rd_hi), .bus_rdata(bus_rdata), .cap_val(cap_val),
    .cap_flag(cap_flag), .cap_irq(cap_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic settle(input logic p, input logic c, input logic s,
                        input logic r, input logic f, input logic t);
    @(negedge clk);
    pin_in = p; cmp_in = c; src_sel_cmp = s; edge_rise = r; filt_en = f; cap_is_top = t;
    repeat (10) @(negedge clk);
    clear_flag();
  endtask

  task automatic t_reset();
    #1;
    check("R11 cap_val", cap_val, 0);
    check("R11 cap_flag", cap_flag, 0);
    check("R11 cap_irq", cap_irq, 0);
    check("R11 bus_rdata", bus_rdata, 0);
  endtask

  task automatic t_rise_pin();
    settle(0, 0, 0, 1, 0, 0);
    @(negedge clk) pin_in = 1'b1;
    edges(2);
    check("R1 no load at k+1", cap_flag, 0);
    edges(1);
    check("R1 flag at k+2", cap_flag, 1);
    check("R1 captured count", cap_val, tmr_count);
    check("R10 irq with enable", cap_irq, 1);
    @(negedge clk) irq_en = 1'b0;
    #1 check("R10 irq gated", cap_irq, 0);
    @(negedge clk) irq_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 flag held", cap_flag, 1);
    clear_flag();
    #1 check("R10 flag cleared", cap_flag, 0);
    check("R10 irq cleared", cap_irq, 0);
  endtask

  task automatic t_set_wins();
    settle(0, 0, 0, 1, 0, 0);
    @(negedge clk) pin_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) flag_clr = 1'b1;
    edges(1);
    check("R10 set beats clear", cap_flag, 1);
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic t_falling();
    settle(1, 0, 0, 0, 0, 0);
    @(negedge clk) pin_in = 1'b0;
    edges(3);
    check("R2 falling captured", cap_flag, 1);
    check("R2 falling value", cap_val, tmr_count);
    clear_flag();
    @(negedge clk) pin_in = 1'b1;
    edges(6);
    check("R2 rising ignored", cap_flag, 0);
  endtask

  task automatic t_overwrite();
    logic [15:0] first;
    settle(0, 0, 0, 1, 0, 0);
    @(negedge clk) pin_in = 1'b1;
    edges(3);
    first = cap_val;
    @(negedge clk) pin_in = 1'b0;
    repeat (4) @(negedge clk);
    pin_in = 1'b1;
    edges(3);
    check("R6 overwritten", cap_val, tmr_count);
    check("R6 differs from first", (cap_val != first), 1);
    check("R6 flag still set", cap_flag, 1);
  endtask

  task automatic t_cmp_source();
    settle(0, 0, 1, 1, 0, 0);
    @(negedge clk) pin_in = 1'b1;
    edges(6);
    check("R1 pin ignored when cmp selected", cap_flag, 0);
    @(negedge clk) cmp_in = 1'b1;
    edges(3);
    check("R1 cmp captured", cap_flag, 1);
    check("R1 cmp value", cap_val, tmr_count);
  endtask

  task automatic t_src_switch();
    settle(1, 0, 1, 1, 0, 0);
    check("R3 quiet before switch", cap_flag, 0);
    @(negedge clk) src_sel_cmp = 1'b0;
    edges(1);
    check("R3 switch captures", cap_flag, 1);
    check("R3 switch value", cap_val, tmr_count);
    clear_flag();
    #1 check("R3 flag clearable", cap_flag, 0);
  endtask

  task automatic t_filter();
    settle(0, 0, 0, 1, 1, 0);
    @(negedge clk) pin_in = 1'b1;
    repeat (3) @(negedge clk);
    pin_in = 1'b0;
    edges(12);
    check("R4 short pulse filtered", cap_flag, 0);
    @(negedge clk) pin_in = 1'b1;
    edges(6);
    check("R5 no load at k+5", cap_flag, 0);
    edges(1);
    check("R5 load at k+6", cap_flag, 1);
    check("R5 filtered value", cap_val, tmr_count);
    @(negedge clk) pin_in = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_top_and_write();
    logic [15:0] held;
    settle(0, 0, 0, 1, 0, 1);
    held = cap_val;
    @(negedge clk) pin_in = 1'b1;
    repeat (5) @(negedge clk);
    pin_in = 1'b0;
    edges(6);
    check("R7 no flag in TOP mode", cap_flag, 0);
    check("R7 value held in TOP mode", cap_val, held);
    @(negedge clk) begin bus_wdata = 8'hAB; bus_wr_hi = 1'b1; end
    @(negedge clk) bus_wr_hi = 1'b0;
    #1 check("R8 high write alone", cap_val, held);
    @(negedge clk) begin bus_wdata = 8'hCD; bus_wr_lo = 1'b1; end
    @(negedge clk) bus_wr_lo = 1'b0;
    #1 check("R8 committed value", cap_val, 16'hABCD);
  endtask

  task automatic t_read();
    @(negedge clk) bus_rd_lo = 1'b1;
    #1 check("R9 low byte", bus_rdata, 8'hCD);
    @(negedge clk) bus_rd_lo = 1'b0;
    #1 check("R9 idle rdata", bus_rdata, 0);
    cap_is_top = 1'b0;
    repeat (4) @(negedge clk);
    pin_in = 1'b1;
    edges(3);
    check("R9 new capture landed", cap_val, tmr_count);
    @(negedge clk) bus_rd_hi = 1'b1;
    #1 check("R9 latched high byte", bus_rdata, 8'hAB);
    @(negedge clk) bus_rd_hi = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_rise_pin();
    t_set_wins();
    t_falling();
    t_overwrite();
    t_cmp_source();
    t_src_switch();
    t_filter();
    t_top_and_write();
    t_read();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule